// File: doc/BRIEF.md
# Converter Startup Mute Sequencer

This block sits on the digital output path of a two-channel audio converter and hides the converter's settling period from downstream logic. It watches the left and right channel power-enable bits. When either bit goes from 0 to 1, it opens a startup window. The window lasts a fixed number of sample periods, and the filter-mode code chosen at that moment sets the number. For the whole window both output words are forced to two's-complement zero. The busy flag stays high until the window closes.

The window is counted in sample strobes, not in clock cycles, so its length follows the sample rate. Filter code 3 is not a legal setting. With that code the sequencer uses the shortest window and raises an error flag. A fresh power-enable rise during an open window starts the count again from zero. When both channels are powered down, the window is abandoned and the outputs are held at zero.

Top module: `adc_warmup_gate`

## Requirements
- R1: A 0-to-1 change on either power-enable input starts a window, and `busy` reads 1 in the cycle after the clock edge that sees the change.
- R2: With `flt_sel` = 2'b00 at the start, `busy` falls at the clock edge that takes the 3088th sample strobe after the start.
- R3: With `flt_sel` = 2'b01 at the start, `busy` falls at the edge that takes the 1552nd strobe.
- R4: With `flt_sel` = 2'b10 at the start, `busy` falls at the edge that takes the 784th strobe.
- R5: With `flt_sel` = 2'b11 at the start, the window is 784 strobes long and `sel_err` is 1 from the next cycle on. `sel_err` clears at a later start with a legal code, or when both channels power down.
- R6: While `busy` is 1, and in the cycle where the starting rise is present, both `dout_l` and `dout_r` are 16'h0000.
- R7: Once the window has closed and at least one channel is powered, `dout_l` equals `din_l` and `dout_r` equals `din_r` in the same cycle.
- R8: A power-enable rise during an open window restarts the count from zero, so a full new window length of strobes is needed after it.
- R9: The count advances only on cycles with `smp_stb` = 1. Without strobes, `busy` stays 1 for any number of cycles.
- R10: When both power-enable inputs are 0, `busy` is 0 from the next edge and both outputs are 16'h0000.
- R11: After reset `busy` and `sel_err` are 0. With both power-enable inputs 0, the outputs are zero.
- R12: The window length is taken at the start. A change of `flt_sel` during the window has no effect on its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_l_en | input | 1 | Left channel power enable |
| pwr_r_en | input | 1 | Right channel power enable |
| flt_sel | input | 2 | Filter-mode code that selects the window length |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| din_l | input | 16 | Left converter word |
| din_r | input | 16 | Right converter word |
| dout_l | output | 16 | Gated left word |
| dout_r | output | 16 | Gated right word |
| busy | output | 1 | Startup window open |
| sel_err | output | 1 | The window was started with the illegal code |

## Verification
The hardest case to reach is a restart in the middle of a window. It needs one channel already powered, a partly used window, and then a rise on the other channel, or on the same channel after a drop while its partner holds power. The bench builds this in order: it starts a window on one channel, spends a counted number of strobes, then raises the second channel. It checks that a full 784 strobes are needed again, not the remainder. Sparse strobes with long idle gaps show that the count follows the strobe rather than the clock.

// File: rtl/adc_warmup_pkg.sv
package adc_warmup_pkg;

  localparam int unsigned LEN_FULL_DEF = 3088;
  localparam int unsigned LEN_HALF_DEF = 1552;
  localparam int unsigned LEN_QTR_DEF  = 784;

  // Window length in sample periods for a filter code; code 3 falls back to the shortest.
  function automatic int unsigned warmup_len(input logic [1:0] code,
                                             input int unsigned len_full,
                                             input int unsigned len_half,
                                             input int unsigned len_qtr);
    case (code)
      2'b00:   return len_full;
      2'b01:   return len_half;
      default: return len_qtr;
    endcase
  endfunction

  function automatic logic code_illegal(input logic [1:0] code);
    return code == 2'b11;
  endfunction

endpackage

// File: rtl/warmup_edge_det.sv
module warmup_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_l,
  input  logic pwr_r,
  output logic rise_o,
  output logic any_on_o
);
  logic prev_l, prev_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l <= 1'b0;
      prev_r <= 1'b0;
    end else begin
      prev_l <= pwr_l;
      prev_r <= pwr_r;
    end
  end

  assign rise_o   = (pwr_l & ~prev_l) | (pwr_r & ~prev_r);
  assign any_on_o = pwr_l | pwr_r;

endmodule

// File: rtl/warmup_timer.sv
module warmup_timer
  import adc_warmup_pkg::*;
#(
  parameter int unsigned LEN_FULL = LEN_FULL_DEF,
  parameter int unsigned LEN_HALF = LEN_HALF_DEF,
  parameter int unsigned LEN_QTR  = LEN_QTR_DEF,
  localparam int unsigned CW = $clog2(LEN_FULL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       any_on,
  input  logic       stb,
  input  logic [1:0] sel,
  output logic       busy_o,
  output logic       err_o
);
  logic [CW-1:0] cnt_q, len_q;
  logic          busy_q, err_q;
  logic          last_tick;

  assign last_tick = busy_q & stb & (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (!any_on) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= CW'(warmup_len(sel, LEN_FULL, LEN_HALF, LEN_QTR));
      err_q  <= code_illegal(sel);
    end else if (busy_q && stb) begin
      if (last_tick) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == '0);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q < len_q);
  assert_hold_no_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stb && !start && any_on) |=> (busy_q && $stable(cnt_q)));
  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel == 2'b11) |=> err_q);
  assert_power_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_on |=> (!busy_q && !err_q));

endmodule

// File: rtl/warmup_mute.sv
module warmup_mute #(
  parameter int unsigned DW = 16
) (
  input  logic          mute,
  input  logic [DW-1:0] d_l,
  input  logic [DW-1:0] d_r,
  output logic [DW-1:0] q_l,
  output logic [DW-1:0] q_r
);
  assign q_l = mute ? '0 : d_l;
  assign q_r = mute ? '0 : d_r;
endmodule

// File: rtl/adc_warmup_gate.sv
module adc_warmup_gate
  import adc_warmup_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned LEN_FULL = LEN_FULL_DEF,
  parameter int unsigned LEN_HALF = LEN_HALF_DEF,
  parameter int unsigned LEN_QTR  = LEN_QTR_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_l_en,
  input  logic          pwr_r_en,
  input  logic [1:0]    flt_sel,
  input  logic          smp_stb,
  input  logic [DW-1:0] din_l,
  input  logic [DW-1:0] din_r,
  output logic [DW-1:0] dout_l,
  output logic [DW-1:0] dout_r,
  output logic          busy,
  output logic          sel_err
);
  logic start_evt, any_on, busy_w, mute_w;

  warmup_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .pwr_l(pwr_l_en), .pwr_r(pwr_r_en),
    .rise_o(start_evt), .any_on_o(any_on)
  );

  warmup_timer #(.LEN_FULL(LEN_FULL), .LEN_HALF(LEN_HALF), .LEN_QTR(LEN_QTR)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .any_on(any_on),
    .stb(smp_stb), .sel(flt_sel), .busy_o(busy_w), .err_o(sel_err)
  );

  assign mute_w = busy_w | start_evt | ~any_on;

  warmup_mute #(.DW(DW)) u_mute (
    .mute(mute_w), .d_l(din_l), .d_r(din_r), .q_l(dout_l), .q_r(dout_r)
  );

  assign busy = busy_w;

  assert_mute_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (dout_l == '0 && dout_r == '0));
  assert_pass_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start_evt && any_on) |-> (dout_l == din_l && dout_r == din_r));
  assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_l_en && !pwr_r_en) |-> (dout_l == '0 && dout_r == '0));

endmodule

// File: tb/sim_adc_warmup_gate.sv
module sim_adc_warmup_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_l_en = 1'b0, pwr_r_en = 1'b0, smp_stb = 1'b0;
  logic [1:0]  flt_sel = 2'b00;
  logic [15:0] din_l = 16'h1234, din_r = 16'hBEEF;
  logic [15:0] dout_l, dout_r;
  logic        busy, sel_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_warmup_gate u0 (
    .clk(clk), .rst_n(rst_n), .pwr_l_en(pwr_l_en), .pwr_r_en(pwr_r_en),
    .flt_sel(flt_sel), .smp_stb(smp_stb), .din_l(din_l), .din_r(din_r),
    .dout_l(dout_l), .dout_r(dout_r), .busy(busy), .sel_err(sel_err)
  );

  function automatic int exp_len(input logic [1:0] c);
    if (c == 2'b00) return 3088;
    if (c == 2'b01) return 1552;
    return 784;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic strobes(input int n);
    smp_stb = 1'b1;
    for (int i = 0; i < n; i++) tick();
    smp_stb = 1'b0;
  endtask

  task automatic power_down();
    pwr_l_en = 1'b0; pwr_r_en = 1'b0; tick();
  endtask

  // R2 R3 R4 R5: full window per code
  task automatic t_window(input logic [1:0] code, input string req);
    int n;
    n = exp_len(code);
    power_down();
    flt_sel = code; pwr_l_en = 1'b1;
    #1; chk("R6", {dout_l, dout_r}, 32'h0);
    tick();
    chk("R1", busy, 1);
    chk(req, sel_err, code == 2'b11);
    strobes(n - 1);
    chk(req, busy, 1);
    chk("R6", {dout_l, dout_r}, 32'h0);
    strobes(1);
    chk(req, busy, 0);
    chk("R7", {dout_l, dout_r}, {din_l, din_r});
  endtask

  task automatic t_restart();
    power_down();
    flt_sel = 2'b10; pwr_l_en = 1'b1; tick();
    strobes(500);
    pwr_r_en = 1'b1; tick();
    chk("R8", busy, 1);
    strobes(783);
    chk("R8", busy, 1);
    strobes(1);
    chk("R8", busy, 0);
    pwr_r_en = 1'b0; tick();
    chk("R8", busy, 0);
    pwr_r_en = 1'b1; tick();
    chk("R1", busy, 1);
    strobes(300);
    pwr_r_en = 1'b0; tick(); pwr_r_en = 1'b1; tick();
    strobes(783);
    chk("R8", busy, 1);
    strobes(1);
    chk("R8", busy, 0);
  endtask

  task automatic t_sparse();
    power_down();
    flt_sel = 2'b10; pwr_r_en = 1'b1; tick();
    for (int i = 0; i < 60; i++) tick();
    chk("R9", busy, 1);
    for (int i = 0; i < 783; i++) begin
      strobes(1); tick(); tick();
    end
    chk("R9", busy, 1);
    strobes(1);
    chk("R9", busy, 0);
  endtask

  task automatic t_sel_change();
    power_down();
    flt_sel = 2'b10; pwr_l_en = 1'b1; tick();
    flt_sel = 2'b00;
    strobes(784);
    chk("R12", busy, 0);
  endtask

  task automatic t_err_clear();
    power_down();
    flt_sel = 2'b11; pwr_l_en = 1'b1; tick();
    chk("R5", sel_err, 1);
    power_down();
    chk("R5", sel_err, 0);
    flt_sel = 2'b11; pwr_l_en = 1'b1; tick();
    pwr_r_en = 1'b1; flt_sel = 2'b01; tick();
    chk("R5", sel_err, 0);
  endtask

  task automatic t_off();
    power_down();
    flt_sel = 2'b00; pwr_l_en = 1'b1; tick();
    strobes(10);
    power_down();
    chk("R10", busy, 0);
    chk("R10", {dout_l, dout_r}, 32'h0);
  endtask

  initial begin
    #1;
    chk("R11", busy, 0);
    chk("R11", sel_err, 0);
    chk("R11", {dout_l, dout_r}, 32'h0);
    #50 rst_n = 1'b1;
    tick();
    chk("R11", busy, 0);
    t_window(2'b00, "R2");
    t_window(2'b01, "R3");
    t_window(2'b10, "R4");
    t_window(2'b11, "R5");
    t_restart();
    t_sparse();
    t_sel_change();
    t_err_clear();
    t_off();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule